// File: doc/BRIEF.md
# BCH Error Location Bit Corrector

This block sits after a BCH error locator in a NAND flash read path. It holds two small byte arrays for one 512-byte sector: the syndrome bytes computed by the ECC engine and the ECC bytes stored in the spare area. Before decoding, it screens these arrays in two ways. It reports a clean sector when every syndrome byte is zero. It reports an erased page when every stored byte is 0xFF. It also offers a byte-reversed view of the syndrome, which is the order the locator expects.

After decoding, the locator streams its error bit locations into the block. The block maps each location, counted from the far end of a combined data-plus-ECC span, to a byte and bit. The flip then goes to one of three places: the sector memory through a read-modify-write port, the internally held stored-ECC bytes, or an invalid-location error. Two modes are supported. The 8-bit-strength mode uses 13 code bytes plus one reserved byte. The 16-bit-strength mode uses 26 code bytes.

Top module: `bch_flip_apply`

## Requirements
- R1: After synchronous reset, busy_o, done_o, err_o, mem_rd_o and mem_we_o are 0 and count_o is 0.
- R2: clean_o is 1 when every syndrome byte of the active span is 0x00. The span is bytes 0..12 with mode_i=0 and bytes 0..25 with mode_i=1. Syndrome byte 13 has no effect with mode_i=0.
- R3: erased_o is 1 when clean_o's condition is false and every stored ECC byte of the same span is 0xFF.
- R4: With rd_sel_i=0, rd_data_o (one cycle later) returns the syndrome in reversed order. With mode_i=0, index k<13 gives byte 12-k and index 13 gives byte 13. With mode_i=1, index k gives byte 25-k. With rd_sel_i=1 it returns stored ECC byte k.
- R5: For location L, the span limit is 525 with mode 0 and 538 with mode 1. The position is limit-1-L/8 and the bit is L%8. A position below 512 causes a sector memory read (mem_rd_o) of that address, followed in the next cycle by a write (mem_we_o) of the read byte with that bit inverted.
- R6: A position of 512 or more, but below the limit, inverts that bit in stored ECC byte position-512, visible through rd_sel_i=1.
- R7: A location with L/8 at or above the limit sets err_o and changes neither memory nor stored ECC. Other locations of the same list are still applied.
- R8: A list longer than 8 (mode 0) or 16 (mode 1) locations sets err_o and applies no flip. A list of exactly the maximum is applied normally.
- R9: loc_fail_i high with the last location sets err_o and applies no flip.
- R10: busy_o is 1 from the cycle after the first location is accepted until the last flip completes. done_o then pulses for one cycle, and count_o holds the number of flips applied.
- R11: The mode is captured with the first location of a list and governs the whole list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0: 13+1 byte code, 1: 26 byte code |
| ld_valid_i | input | 1 | Load one byte into the syndrome or stored array |
| ld_sel_i | input | 1 | 0: syndrome array, 1: stored ECC array |
| ld_idx_i | input | 5 | Byte index of the load |
| ld_data_i | input | 8 | Byte to load |
| rd_sel_i | input | 1 | 0: reversed syndrome view, 1: stored ECC |
| rd_idx_i | input | 5 | Read index |
| rd_data_o | output | 8 | Read data, registered |
| clean_o | output | 1 | All syndrome bytes zero |
| erased_o | output | 1 | Not clean and all stored bytes 0xFF |
| loc_valid_i | input | 1 | Error location valid |
| loc_i | input | 13 | Error bit location |
| loc_last_i | input | 1 | Last location of the list |
| loc_fail_i | input | 1 | Locator failure, sampled with the last location |
| mem_rd_o | output | 1 | Sector memory read strobe |
| mem_we_o | output | 1 | Sector memory write strobe |
| mem_addr_o | output | 9 | Sector memory byte address |
| mem_wdata_o | output | 8 | Sector memory write data |
| mem_rdata_i | input | 8 | Sector memory read data, one cycle after mem_rd_o |
| busy_o | output | 1 | List being processed |
| done_o | output | 1 | One-cycle end-of-list pulse |
| err_o | output | 1 | Overflow, locator failure or invalid location in the last list |
| count_o | output | 5 | Flips applied in the last list |

## Verification
The hardest cases to reach are the ends of the span. A location has to land exactly on byte 0 of the data, on the last stored ECC byte, and one byte past the limit, in each mode. The location list also has to sit exactly at, and one past, the mode's maximum length. The bench builds these location values arithmetically from the limit. It feeds maximum-length and over-length lists, then compares the whole sector memory and every stored byte against a behavioural model. During each run, every memory write is also checked against the set of addresses the model expects to touch.

// File: rtl/bch_flip_pkg.sv
package bch_flip_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_COLL, ST_CHECK, ST_ACT, ST_WB, ST_DONE
  } flip_state_t;

  typedef enum logic [1:0] {
    K_DATA, K_ECC, K_BAD
  } flip_kind_t;
endpackage

// File: rtl/bch_loc_map.sv
module bch_loc_map #(
  parameter int SECTOR = 512,
  parameter int CODE8  = 13,
  parameter int CODE16 = 26,
  parameter int LOC_W  = 13,
  parameter int POS_W  = 10,
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 5
) (
  input  logic                     mode,
  input  logic [LOC_W-1:0]         loc,
  output bch_flip_pkg::flip_kind_t kind,
  output logic [ADDR_W-1:0]        addr,
  output logic [IDX_W-1:0]         eidx,
  output logic [7:0]               mask
);
  localparam int LB_W = LOC_W - 3;
  localparam int CW_W = (LB_W > POS_W) ? LB_W : POS_W;

  logic [CW_W-1:0] lbyte, limit, pos, epos;

  always_comb begin
    lbyte = CW_W'(loc[LOC_W-1:3]);
    limit = mode ? CW_W'(SECTOR + CODE16) : CW_W'(SECTOR + CODE8);
    pos   = limit - CW_W'(1) - lbyte;
    epos  = pos - CW_W'(SECTOR);
    mask  = 8'(1) << loc[2:0];
    addr  = pos[ADDR_W-1:0];
    eidx  = epos[IDX_W-1:0];
    if (lbyte >= limit)              kind = bch_flip_pkg::K_BAD;
    else if (pos < CW_W'(SECTOR))    kind = bch_flip_pkg::K_DATA;
    else                             kind = bch_flip_pkg::K_ECC;
  end
endmodule

// File: rtl/bch_code_store.sv
module bch_code_store #(
  parameter int CODE8  = 13,
  parameter int CODE16 = 26,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             ld_en,
  input  logic             ld_sel,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             flip_en,
  input  logic [IDX_W-1:0] flip_idx,
  input  logic [7:0]       flip_mask,
  input  logic             rd_sel,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             clean,
  output logic             erased
);
  logic [7:0] syn [CODE16];
  logic [7:0] sto [CODE16];
  logic all_zero, all_ff;
  logic [IDX_W-1:0] top_i, rev_i;

  always_comb begin
    all_zero = 1'b1;
    all_ff   = 1'b1;
    for (int i = 0; i < CODE16; i++) begin
      if (mode || i < CODE8) begin
        if (syn[i] != 8'h00) all_zero = 1'b0;
        if (sto[i] != 8'hFF) all_ff   = 1'b0;
      end
    end
  end

  always_comb begin
    top_i = mode ? IDX_W'(CODE16 - 1) : IDX_W'(CODE8 - 1);
    rev_i = (rd_idx <= top_i) ? (top_i - rd_idx) : rd_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CODE16; i++) begin
        syn[i] <= 8'h00;
        sto[i] <= 8'h00;
      end
      rd_data <= 8'h00;
      clean   <= 1'b0;
      erased  <= 1'b0;
    end else begin
      if (ld_en) begin
        if (ld_sel) sto[ld_idx] <= ld_data;
        else        syn[ld_idx] <= ld_data;
      end else if (flip_en) begin
        sto[flip_idx] <= sto[flip_idx] ^ flip_mask;
      end
      rd_data <= rd_sel ? sto[rd_idx] : syn[rev_i];
      clean   <= all_zero;
      erased  <= !all_zero && all_ff;
    end
  end
endmodule

// File: rtl/bch_flip_apply.sv
module bch_flip_apply #(
  parameter int SECTOR = 512,
  parameter int CODE8  = 13,
  parameter int CODE16 = 26,
  parameter int MAX8   = 8,
  parameter int MAX16  = 16,
  localparam int IDX_W  = $clog2(CODE16),
  localparam int ADDR_W = $clog2(SECTOR),
  localparam int POS_W  = $clog2(SECTOR + CODE16),
  localparam int LOC_W  = $clog2(8 * (SECTOR + CODE16)),
  localparam int CNT_W  = $clog2(MAX16 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              ld_valid_i,
  input  logic              ld_sel_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [7:0]        ld_data_i,
  input  logic              rd_sel_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic              clean_o,
  output logic              erased_o,
  input  logic              loc_valid_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic              loc_last_i,
  input  logic              loc_fail_i,
  output logic              mem_rd_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  count_o
);
  import bch_flip_pkg::*;
  localparam int LI_W = $clog2(MAX16);

  flip_state_t        st_q;
  logic [LOC_W-1:0]   list_q [MAX16];
  logic [CNT_W-1:0]   cnt_q, applied_q;
  logic [LI_W-1:0]    idx_q;
  logic               mode_q, ovf_q, fail_q, bad_q;
  logic [ADDR_W-1:0]  pos_q;
  logic [7:0]         mask_q;
  logic [CNT_W-1:0]   max_n;
  logic               last_item;

  flip_kind_t         m_kind;
  logic [ADDR_W-1:0]  m_addr;
  logic [IDX_W-1:0]   m_eidx;
  logic [7:0]         m_mask;

  bch_loc_map #(
    .SECTOR(SECTOR), .CODE8(CODE8), .CODE16(CODE16), .LOC_W(LOC_W),
    .POS_W(POS_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) map_i (
    .mode(mode_q), .loc(list_q[idx_q]), .kind(m_kind),
    .addr(m_addr), .eidx(m_eidx), .mask(m_mask)
  );

  logic ecc_flip;
  assign ecc_flip = (st_q == ST_ACT) && (m_kind == K_ECC);

  bch_code_store #(.CODE8(CODE8), .CODE16(CODE16), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst(rst), .mode(mode_i),
    .ld_en(ld_valid_i && !busy_o), .ld_sel(ld_sel_i), .ld_idx(ld_idx_i),
    .ld_data(ld_data_i), .flip_en(ecc_flip), .flip_idx(m_eidx),
    .flip_mask(m_mask), .rd_sel(rd_sel_i), .rd_idx(rd_idx_i),
    .rd_data(rd_data_o), .clean(clean_o), .erased(erased_o)
  );

  assign max_n     = mode_q ? CNT_W'(MAX16) : CNT_W'(MAX8);
  assign last_item = (CNT_W'(idx_q) == cnt_q - CNT_W'(1));

  // Location list storage: no reset so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (st_q == ST_IDLE && loc_valid_i)
      list_q[0] <= loc_i;
    else if (st_q == ST_COLL && loc_valid_i && cnt_q != max_n)
      list_q[cnt_q[LI_W-1:0]] <= loc_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      applied_q <= '0;
      idx_q     <= '0;
      mode_q    <= 1'b0;
      ovf_q     <= 1'b0;
      fail_q    <= 1'b0;
      bad_q     <= 1'b0;
      pos_q     <= '0;
      mask_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (loc_valid_i) begin
          cnt_q     <= CNT_W'(1);
          mode_q    <= mode_i;
          ovf_q     <= 1'b0;
          bad_q     <= 1'b0;
          applied_q <= '0;
          fail_q    <= loc_last_i && loc_fail_i;
          st_q      <= loc_last_i ? ST_CHECK : ST_COLL;
        end
        ST_COLL: if (loc_valid_i) begin
          if (cnt_q == max_n) ovf_q <= 1'b1;
          else                cnt_q <= cnt_q + CNT_W'(1);
          if (loc_last_i) begin
            fail_q <= loc_fail_i;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          idx_q <= '0;
          st_q  <= (ovf_q || fail_q) ? ST_DONE : ST_ACT;
        end
        ST_ACT: begin
          if (m_kind == K_DATA) begin
            pos_q  <= m_addr;
            mask_q <= m_mask;
            st_q   <= ST_WB;
          end else begin
            if (m_kind == K_ECC) applied_q <= applied_q + CNT_W'(1);
            else                 bad_q     <= 1'b1;
            if (last_item) st_q  <= ST_DONE;
            else           idx_q <= idx_q + LI_W'(1);
          end
        end
        ST_WB: begin
          applied_q <= applied_q + CNT_W'(1);
          if (last_item) st_q <= ST_DONE;
          else begin
            idx_q <= idx_q + LI_W'(1);
            st_q  <= ST_ACT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd_o    = (st_q == ST_ACT) && (m_kind == K_DATA);
    mem_we_o    = (st_q == ST_WB);
    mem_addr_o  = (st_q == ST_WB) ? pos_q : m_addr;
    mem_wdata_o = mem_rdata_i ^ mask_q;
  end

  assign busy_o  = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o  = (st_q == ST_DONE);
  assign err_o   = ovf_q || fail_q || bad_q;
  assign count_o = applied_q;
endmodule

module bch_flip_apply_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              clean_o,
  input logic              erased_o
);
  // R5: a write follows a read of the same address
  p_wb_after_rd_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ($past(mem_rd_o) && $past(mem_addr_o) == mem_addr_o));

  // R5: every read is followed by its write
  p_rd_then_wb_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> mem_we_o);

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: done only ends a busy interval
  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(busy_o));

  // R10: no memory traffic while idle
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mem_rd_o && !mem_we_o));

  // R3: erased and clean never together
  p_erased_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(clean_o && erased_o));
endmodule

bind bch_flip_apply bch_flip_apply_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .mem_rd_o(mem_rd_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .busy_o(busy_o), .done_o(done_o),
  .clean_o(clean_o), .erased_o(erased_o)
);

// File: tb/bch_flip_apply_tb.sv
`timescale 1ns/1ps
module bch_flip_apply_tb_top;
  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic mode_i = 0, ld_valid_i = 0, ld_sel_i = 0, rd_sel_i = 0;
  logic [4:0] ld_idx_i = 0, rd_idx_i = 0;
  logic [7:0] ld_data_i = 0, rd_data_o;
  logic clean_o, erased_o;
  logic loc_valid_i = 0, loc_last_i = 0, loc_fail_i = 0;
  logic [12:0] loc_i = 0;
  logic mem_rd_o, mem_we_o;
  logic [8:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata_i;
  logic busy_o, done_o, err_o;
  logic [4:0] count_o;

  bch_flip_apply dut_i (.*);

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  logic [7:0] exp_ecc [26];
  bit touch [512];
  int tests = 0, fails = 0;

  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  // per-clock reference: every write must target an address the model flips
  always @(negedge clk) if (!rst && mem_we_o) begin
    tests++;
    if (!touch[mem_addr_o]) begin
      fails++;
      $display("FAIL R5 write addr actual=%0d expected=none of untouched", mem_addr_o);
    end
  end

  task automatic chk(input string r, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  task automatic ld(input bit sel, input int idx, input int d);
    @(negedge clk);
    ld_valid_i = 1; ld_sel_i = sel; ld_idx_i = 5'(idx); ld_data_i = 8'(d);
    @(negedge clk);
    ld_valid_i = 0;
  endtask

  task automatic rd(input bit sel, input int idx, output int d);
    @(negedge clk);
    rd_sel_i = sel; rd_idx_i = 5'(idx);
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic run_job(input string r, input bit md, input int locs[20],
                         input int n, input bit fl);
    int limit, mx, ecnt, d;
    bit eerr;
    limit = 512 + (md ? 26 : 13);
    mx = md ? 16 : 8;
    ecnt = 0; eerr = 0;
    for (int i = 0; i < 512; i++) touch[i] = 0;
    if (n > mx || fl) eerr = 1;
    else begin
      for (int i = 0; i < n; i++) begin
        int b, p;
        b = locs[i] / 8;
        if (b >= limit) eerr = 1;
        else begin
          p = limit - 1 - b;
          ecnt++;
          if (p < 512) begin
            exp_mem[p] ^= 8'(1 << (locs[i] % 8));
            touch[p] = 1;
          end else exp_ecc[p-512] ^= 8'(1 << (locs[i] % 8));
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mode_i = md; loc_valid_i = 1; loc_i = 13'(locs[i]);
      loc_last_i = (i == n - 1); loc_fail_i = fl;
    end
    @(negedge clk);
    loc_valid_i = 0; loc_last_i = 0; loc_fail_i = 0;
    chk({r, " R10 busy"}, busy_o, 1);
    for (int k = 0; k < 200 && !done_o; k++) @(negedge clk);
    chk({r, " R10 done"}, done_o, 1);
    chk({r, " err"}, err_o, eerr);
    chk({r, " R10 count"}, count_o, ecnt);
    @(negedge clk);
    chk({r, " R10 pulse"}, {done_o, busy_o}, 0);
    begin
      int bad = -1;
      for (int i = 0; i < 512; i++) if (mem[i] != exp_mem[i] && bad < 0) bad = i;
      chk({r, " R5 memory mismatch index"}, bad, -1);
    end
    for (int i = 0; i < 26; i++) begin
      rd(1, i, d);
      if (d != exp_ecc[i]) chk({r, " R6 stored ecc"}, d, exp_ecc[i]);
    end
    tests++;
  endtask

  initial begin
    int d;
    int L[20];
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0); chk("R1 count", count_o, 0);
    chk("R1 mem strobes", {mem_rd_o, mem_we_o}, 0);

    // screening
    for (int i = 0; i < 26; i++) ld(0, i, 0);
    ld(0, 13, 8'h5A);
    mode_i = 0; settle();
    chk("R2 clean mode0 ignores byte 13", clean_o, 1);
    mode_i = 1; settle();
    chk("R2 clean mode1 sees byte 13", clean_o, 0);
    for (int i = 0; i < 26; i++) ld(1, i, 8'hFF);
    settle();
    chk("R3 erased", erased_o, 1);
    ld(1, 20, 8'h00);
    settle();
    chk("R3 erased mode1 broken", erased_o, 0);
    mode_i = 0; settle();
    chk("R3 erased mode0 outside span", erased_o, 0);
    ld(0, 13, 0); ld(0, 3, 1); settle();
    chk("R3 erased mode0 not clean", erased_o, 1);
    chk("R2 not clean", clean_o, 0);

    // reversal
    for (int i = 0; i < 26; i++) ld(0, i, i + 1);
    mode_i = 0;
    rd(0, 0, d);  chk("R4 mode0 idx0", d, 13);
    rd(0, 12, d); chk("R4 mode0 idx12", d, 1);
    rd(0, 13, d); chk("R4 mode0 idx13", d, 14);
    mode_i = 1;
    rd(0, 0, d);  chk("R4 mode1 idx0", d, 26);
    rd(0, 25, d); chk("R4 mode1 idx25", d, 1);

    for (int i = 0; i < 26; i++) begin
      ld(1, i, 8'hA0 + i);
      exp_ecc[i] = 8'(8'hA0 + i);
    end

    L[0] = 8*524+7; L[1] = 3; L[2] = 8*100+2; L[3] = 8*524+1;
    run_job("J1 R5 R6 mode0", 0, L, 4, 0);
    L[0] = 0; L[1] = 8*537+5; L[2] = 8*300;
    run_job("J2 R11 mode1", 1, L, 3, 0);
    L[0] = 8*525; L[1] = 8*10+4;
    run_job("J3 R7 invalid", 0, L, 2, 0);
    L[0] = 8*538; L[1] = 8*600+6; L[2] = 8*537;
    run_job("J4 R7 mode1 limit", 1, L, 3, 0);
    for (int i = 0; i < 9; i++) L[i] = 8*(200+i);
    run_job("J5 R8 overflow", 0, L, 9, 0);
    for (int i = 0; i < 16; i++) L[i] = 8*(50+3*i) + (i % 8);
    run_job("J6 R8 max mode1", 1, L, 16, 0);
    for (int i = 0; i < 17; i++) L[i] = 8*(60+i);
    run_job("J7 R8 overflow mode1", 1, L, 17, 0);
    L[0] = 8*5; L[1] = 2;
    run_job("J8 R9 fail", 0, L, 2, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule